// File: doc/BRIEF.md
# SPI Control and Status Register Unit

This block is the register and flag layer of a serial peripheral interface controller. It holds the enable bit and the configuration bits, and keeps the four status flags: receive full, overflow, mode fault and transmit empty. The CPU reads and writes these through a simple register bus. A separate shift engine reports its events as single-cycle strobes. From these the unit drives a CPU interrupt request, two DMA service requests, and the effective enable, master select and rate select that the engine uses.

The unit also sets the reset scope. Only the system reset returns the control bits and flags to their initial values. Clearing the enable bit stops the engine but keeps every configuration bit and every pending flag. The receive-full, overflow and mode-fault flags are cleared in two steps: a status read while the flag is set arms the clear, and a later data-register access completes it. While a break state is active and break-clear is not enabled, no bus access can change a flag or arm a clear. An arming done before the break is kept through it. A mode fault seen by an enabled master with fault detection on sets its flag and turns the unit off.

A stop input holds the engine enable low without touching any register. If a system reset arrives while stop is high, an abort strobe goes to the engine.

Top module: `spi_regfile_ctl`

## Requirements
- R1: The synchronous active-low reset clears all control bits, the receive-full, overflow and mode-fault flags, and the abort output is low when stop is low. It sets transmit-empty. After reset, address 0 reads 0x00 and address 1 reads 0x10.
- R2: A write to address 0 stores en (bit 0), master (bit 1), rx-interrupt enable (bit 2) and tx-interrupt enable (bit 3), and these read back at the same positions. A write to address 1 stores fault-enable (bit 3), error-interrupt enable (bit 2) and rate (bits 1:0). Address 1 reads the flags at receive-full bit 7, overflow bit 6, mode-fault bit 5 and transmit-empty bit 4; writes to those bits are ignored. The engine enable equals en while stop is low, the master output follows bit 1 and the rate output follows bits 1:0.
- R3: Writing en to 0 leaves the other control bits, the configuration bits and all flags unchanged, and the flags keep driving the interrupt.
- R4: A receive-full, overflow or mode-fault flag is cleared by a read of address 1 while the flag is set, followed by a read or write of address 2. A data access with no prior arming read leaves the flag set.
- R5: The interrupt is (receive-full AND rx-interrupt enable) OR (transmit-empty AND tx-interrupt enable) OR ((overflow OR mode-fault) AND error-interrupt enable).
- R6: A mode-fault strobe while en, master and fault-enable are all 1 sets the mode-fault flag and clears en. With fault-enable at 0 the strobe sets no flag and en stays 1.
- R7: While break is high and break-clear is 0, reads and writes change no flag and arm no clear. Transmit-empty is not cleared by a data write in this state.
- R8: While break is high and break-clear is 1, both clearing sequences work normally, and a flag cleared this way stays cleared after break ends.
- R9: An arming read done before break survives a break with break-clear at 0. A data access during that break does not clear the flag. The first data access after break clears it.
- R10: A setting strobe in the same cycle as a clearing step leaves the flag set. A setting strobe between the two steps cancels the arming.
- R11: While stop is high, the engine enable is 0 and register contents are kept. A reset taken while stop is high raises the abort output for the cycles that reset is held, and it drops after reset ends.
- R12: Transmit-empty is set by the engine's tx-free strobe and cleared by a write of address 2 alone. That write pulses tx-load with the written byte. The rx DMA request equals receive-full, and the tx DMA request equals transmit-empty AND en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_addr | input | 2 | Register address: 0 control, 1 config/status, 2 data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ev_rx_done | input | 1 | Engine: byte received |
| ev_rx_ovf | input | 1 | Engine: receive overrun |
| ev_tx_free | input | 1 | Engine: transmit buffer free |
| ev_ss_fault | input | 1 | Engine: select-line conflict seen |
| eng_rx_byte | input | 8 | Engine received byte, returned on data reads |
| brk_i | input | 1 | Break state active |
| brk_clr_en | input | 1 | Allow flag clearing during break |
| stop_i | input | 1 | Stop mode active |
| irq_o | output | 1 | CPU interrupt request |
| dma_rx_o | output | 1 | Receive DMA service request |
| dma_tx_o | output | 1 | Transmit DMA service request |
| eng_enable_o | output | 1 | Effective engine enable |
| eng_master_o | output | 1 | Master select to engine |
| eng_rate_o | output | 2 | Rate select to baud generator |
| tx_load_o | output | 1 | Pulse: new transmit byte |
| tx_byte_o | output | 8 | Transmit byte |
| xfer_abort_o | output | 1 | Abort strobe on reset during stop |

## Verification
The bench sweeps every control and configuration value and every interrupt-enable mask against single-flag states. It catches a wrong bit position and an overflow that interrupts with error interrupts off. It then targets the clearing corners. If a design clears on the data access alone, the flag would drop too early. If a design lets the break block a clear that was armed before it, the post-break access would leave the flag stuck. If a design lets a clear win over a simultaneous event, a received byte would be lost. The bench also checks that disabling the unit wipes nothing, that a mode fault turns the unit off only when fault detection is on, and that a reset during stop produces the abort strobe.

// File: rtl/spi_reg_pkg.sv
// Package: shared widths, register addresses, flag indices and control
// record types for the SPI register unit.
package spi_reg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 2;
    localparam int CTL_W  = 4;
    localparam int NFLAG  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    // flag indices; status bit of flag i is DATA_W-1-i
    localparam int F_RX  = 0;
    localparam int F_OVF = 1;
    localparam int F_MF  = 2;
    localparam int F_TXE = 3;

    typedef struct packed {
        logic txie;
        logic rxie;
        logic master;
        logic en;
    } ctrl_a_t;

    typedef struct packed {
        logic              mfen;
        logic              errie;
        logic [RATE_W-1:0] rate;
    } cfg_t;
endpackage

// File: rtl/spi_ctl_bank.sv
// Module: holds the two control registers. Only the system reset clears
// them; a qualified mode fault forces the enable bit low and wins over a
// same-cycle write. Assumes single-cycle write strobes.
module spi_ctl_bank
    import spi_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_cfg,
    input  logic [CTL_W-1:0] wbits,
    input  logic             fault_kill,
    output ctrl_a_t          ctrl,
    output cfg_t             cfg
);
    // Purpose: load control fields on writes, drop enable on a mode fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            cfg  <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_a_t'(wbits);
            if (wr_cfg)  cfg  <= cfg_t'(wbits);
            if (fault_kill) ctrl.en <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_flag_cell.sv
// Module: one status flag. Hardware events set it and always take
// priority. With TWO_STEP set, a status read while the flag is set arms
// the clear and a later data access completes it; without TWO_STEP a
// single clear step suffices. 'protect' freezes all bus-driven change.
module spi_flag_cell #(
    parameter bit TWO_STEP = 1'b1,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic arm_req,
    input  logic clr_step,
    input  logic protect,
    output logic flag,
    output logic armed
);
    logic allow;
    assign allow = !protect;

    generate
        if (TWO_STEP) begin : g_two
            // Purpose: set on event, arm on status read, clear on data access.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag  <= RST_VAL;
                    armed <= 1'b0;
                end else if (set_ev) begin
                    flag  <= 1'b1;
                    armed <= 1'b0;
                end else if (allow && armed && clr_step) begin
                    flag  <= 1'b0;
                    armed <= 1'b0;
                end else if (allow && arm_req && flag) begin
                    armed <= 1'b1;
                end
            end
        end else begin : g_one
            // Purpose: set on event, clear on a single access.
            always_ff @(posedge clk) begin
                if (!rst_n)                    flag <= RST_VAL;
                else if (set_ev)               flag <= 1'b1;
                else if (allow && clr_step)    flag <= 1'b0;
            end
            assign armed = 1'b0;
            logic unused_arm;
            assign unused_arm = arm_req;
        end
    endgenerate
endmodule

// File: rtl/spi_irq_merge.sv
// Module: combines flags and enables into the CPU interrupt, the two DMA
// requests and the engine enable gated by stop mode. Pure combinational.
module spi_irq_merge
    import spi_reg_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  ctrl_a_t          ctrl,
    input  cfg_t             cfg,
    input  logic             stop_i,
    output logic             irq,
    output logic             dma_rx,
    output logic             dma_tx,
    output logic             eng_en
);
    logic unused_cfg;
    // Purpose: form request and enable outputs.
    always_comb begin
        irq    = (flags[F_RX]  && ctrl.rxie)
               || (flags[F_TXE] && ctrl.txie)
               || ((flags[F_OVF] || flags[F_MF]) && cfg.errie);
        dma_rx = flags[F_RX];
        dma_tx = flags[F_TXE] && ctrl.en;
        eng_en = ctrl.en && !stop_i;
        unused_cfg = cfg.mfen ^ (^cfg.rate);
    end
endmodule

// File: rtl/spi_regfile_ctl.sv
// Module: top of the SPI register unit. Decodes the register bus, routes
// engine strobes into the flag cells, and drives interrupt, DMA and engine
// control outputs. Assumes single-cycle bus strobes and engine strobes
// already in this clock domain.
module spi_regfile_ctl
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_rx_done,
    input  logic              ev_rx_ovf,
    input  logic              ev_tx_free,
    input  logic              ev_ss_fault,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              brk_i,
    input  logic              brk_clr_en,
    input  logic              stop_i,
    output logic              irq_o,
    output logic              dma_rx_o,
    output logic              dma_tx_o,
    output logic              eng_enable_o,
    output logic              eng_master_o,
    output logic [RATE_W-1:0] eng_rate_o,
    output logic              tx_load_o,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              xfer_abort_o
);
    ctrl_a_t          ctrl;
    cfg_t             cfg;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] armed_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic             wr_ctrl, wr_cfg, rd_cfg, data_acc, data_wr;
    logic             fault_kill, protect, en_bit, abort_q;
    logic [CTL_W-1:0] cfg_bits;

    // Purpose: bus decode.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_cfg   = bus_wr && (bus_addr == A_CFG);
        rd_cfg   = bus_rd && (bus_addr == A_CFG);
        data_wr  = bus_wr && (bus_addr == A_DATA);
        data_acc = (bus_wr || bus_rd) && (bus_addr == A_DATA);
        protect  = brk_i && !brk_clr_en;
    end

    assign fault_kill = ev_ss_fault && ctrl.en && ctrl.master && cfg.mfen;

    // Purpose: per-flag set and clear sources.
    always_comb begin
        set_vec        = '0;
        set_vec[F_RX]  = ev_rx_done;
        set_vec[F_OVF] = ev_rx_ovf;
        set_vec[F_MF]  = fault_kill;
        set_vec[F_TXE] = ev_tx_free;
        clr_vec        = {NFLAG{data_acc}};
        clr_vec[F_TXE] = data_wr;
    end

    spi_ctl_bank u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_cfg     (wr_cfg),
        .wbits      (bus_wdata[CTL_W-1:0]),
        .fault_kill (fault_kill),
        .ctrl       (ctrl),
        .cfg        (cfg)
    );

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            spi_flag_cell #(
                .TWO_STEP (bit'(g != F_TXE)),
                .RST_VAL  (bit'(g == F_TXE))
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_ev   (set_vec[g]),
                .arm_req  (rd_cfg),
                .clr_step (clr_vec[g]),
                .protect  (protect),
                .flag     (flag_q[g]),
                .armed    (armed_q[g])
            );
        end
    endgenerate

    spi_irq_merge u_merge (
        .flags  (flag_q),
        .ctrl   (ctrl),
        .cfg    (cfg),
        .stop_i (stop_i),
        .irq    (irq_o),
        .dma_rx (dma_rx_o),
        .dma_tx (dma_tx_o),
        .eng_en (eng_enable_o)
    );

    // Purpose: abort strobe while reset is taken during stop.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= stop_i;
        else        abort_q <= 1'b0;
    end

    // Purpose: read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[CTL_W-1:0] = ctrl;
            A_CFG: begin
                bus_rdata[CTL_W-1:0] = cfg;
                for (int i = 0; i < NFLAG; i++)
                    bus_rdata[DATA_W-1-i] = flag_q[i];
            end
            A_DATA:  bus_rdata = eng_rx_byte;
            default: bus_rdata = '0;
        endcase
    end

    logic unused_armed;
    assign unused_armed = ^armed_q;
    assign en_bit       = ctrl.en;
    assign cfg_bits     = cfg;
    assign eng_master_o = ctrl.master;
    assign eng_rate_o   = cfg.rate;
    assign tx_load_o    = data_wr;
    assign tx_byte_o    = bus_wdata;
    assign xfer_abort_o = abort_q;
endmodule

// File: rtl/spi_regfile_chk.sv
// Module: property checker for spi_regfile_ctl, attached through bind.
module spi_regfile_chk
    import spi_reg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en_bit,
    input logic             master,
    input logic [CTL_W-1:0] cfg_bits,
    input logic [NFLAG-1:0] flag_q,
    input logic [ctrl_w_dummy_fix(0):0] dummy_unused,
    input logic             ev_rx_done,
    input logic             ev_rx_ovf,
    input logic             ev_tx_free,
    input logic             ev_ss_fault,
    input logic             brk_i,
    input logic             brk_clr_en,
    input logic             stop_i,
    input logic             eng_enable_o,
    input logic             irq_o,
    input logic [DATA_W-1:0] rd_ctrl_view,
    input logic             bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    function automatic int ctrl_w_dummy_fix(input int x);
        return x;
    endfunction

    logic ev_any, rxie, txie;
    assign ev_any = ev_rx_done || ev_rx_ovf || ev_tx_free || ev_ss_fault;
    assign rxie   = rd_ctrl_view[2];
    assign txie   = rd_ctrl_view[3];

    // R6
    mfault_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bit && master && cfg_bits[3] && ev_ss_fault) |=> (!en_bit && flag_q[F_MF]));

    // R7
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !brk_clr_en && !ev_any) |=> $stable(flag_q));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> flag_q[F_RX]);

    // R10
    txe_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_free |=> flag_q[F_TXE]);

    // R5
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bits[2] && !(flag_q[F_RX] && rxie) && !(flag_q[F_TXE] && txie)) |-> !irq_o);

    // R11
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !eng_enable_o);

    // R3
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_CFG) |=> $stable(cfg_bits));

    logic unused_d;
    assign unused_d = ^dummy_unused;
endmodule

bind spi_regfile_ctl spi_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_bit       (en_bit),
    .master       (eng_master_o),
    .cfg_bits     (cfg_bits),
    .flag_q       (flag_q),
    .dummy_unused (1'b0),
    .ev_rx_done   (ev_rx_done),
    .ev_rx_ovf    (ev_rx_ovf),
    .ev_tx_free   (ev_tx_free),
    .ev_ss_fault  (ev_ss_fault),
    .brk_i        (brk_i),
    .brk_clr_en   (brk_clr_en),
    .stop_i       (stop_i),
    .eng_enable_o (eng_enable_o),
    .irq_o        (irq_o),
    .rd_ctrl_view ({4'b0, ctrl}),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr)
);

// File: tb/test_spi_regfile_ctl.sv
`timescale 1ns/100ps
module test_spi_regfile_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, eng_rx_byte = 8'h5C, tx_byte_o;
    logic       ev_rx_done = 0, ev_rx_ovf = 0, ev_tx_free = 0, ev_ss_fault = 0;
    logic       brk_i = 0, brk_clr_en = 0, stop_i = 0;
    logic       irq_o, dma_rx_o, dma_tx_o, eng_enable_o, eng_master_o;
    logic [1:0] eng_rate_o;
    logic       tx_load_o, xfer_abort_o;
    int         n_cmp = 0, n_bad = 0;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    spi_regfile_ctl i_spi_regfile_ctl (.*);

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 abort", {7'b0, xfer_abort_o}, 8'h00);
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 status", d, 8'h10);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R1 eng_en", {7'b0, eng_enable_o}, 8'h00);

        // R2 control sweeps
        for (int v = 0; v < 16; v++) begin
            wr(2'd0, 8'(v));
            rd(2'd0, d); chk("R2 ctrl readback", d, 8'(v));
            chk("R2 eng_en", {7'b0, eng_enable_o}, {7'b0, v[0]});
            chk("R2 master", {7'b0, eng_master_o}, {7'b0, v[1]});
        end
        for (int v = 0; v < 16; v++) begin
            wr(2'd1, 8'hF0 | 8'(v));
            rd(2'd1, d); chk("R2 cfg readback", d, 8'h10 | 8'(v));
            chk("R2 rate", {6'b0, eng_rate_o}, {6'b0, 2'(v)});
        end
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);

        // R12 transmit empty and DMA
        wr(2'd0, 8'h01);
        chk("R12 dma_tx on", {7'b0, dma_tx_o}, 8'h01);
        bus_addr = 2'd2; bus_wdata = 8'hA5; bus_wr = 1'b1;
        #1 chk("R12 tx_load", {7'b0, tx_load_o}, 8'h01);
        chk("R12 tx_byte", tx_byte_o, 8'hA5);
        tick(); bus_wr = 1'b0;
        chk("R12 dma_tx after write", {7'b0, dma_tx_o}, 8'h00);
        rd(2'd1, d); chk("R12 txe cleared", d, 8'h00);
        ev_tx_free = 1; tick(); ev_tx_free = 0;
        chk("R12 dma_tx on free", {7'b0, dma_tx_o}, 8'h01);
        wr(2'd0, 8'h00);
        chk("R12 dma_tx gated by en", {7'b0, dma_tx_o}, 8'h00);
        rd(2'd2, d); chk("R12 data read", d, 8'h5C);

        // R5 interrupt masks, transmit-empty only
        for (int m = 0; m < 8; m++) begin
            wr(2'd0, {4'b0, m[1], m[0], 2'b00});
            wr(2'd1, {5'b0, m[2], 2'b00});
            chk("R5 txe irq", {7'b0, irq_o}, {7'b0, m[1]});
        end
        wr(2'd2, 8'h00);
        ev_rx_ovf = 1; tick(); ev_rx_ovf = 0;
        for (int m = 0; m < 8; m++) begin
            wr(2'd0, {4'b0, m[1], m[0], 2'b00});
            wr(2'd1, {5'b0, m[2], 2'b00});
            chk("R5 ovf irq", {7'b0, irq_o}, {7'b0, m[2]});
        end
        rd(2'd1, d); chk("R4 ovf status", d, 8'h44);
        rd(2'd2, d);
        rd(2'd1, d); chk("R4 ovf cleared", d, 8'h04);
        ev_rx_done = 1; tick(); ev_rx_done = 0;
        for (int m = 0; m < 8; m++) begin
            wr(2'd0, {4'b0, m[1], m[0], 2'b00});
            wr(2'd1, {5'b0, m[2], 2'b00});
            chk("R5 rx irq", {7'b0, irq_o}, {7'b0, m[0]});
            chk("R12 dma_rx", {7'b0, dma_rx_o}, 8'h01);
        end

        // R4 two-step clear of receive full
        rd(2'd2, d); chk("R4 no arm keeps", {7'b0, dma_rx_o}, 8'h01);
        rd(2'd1, d); rd(2'd2, d);
        chk("R4 armed clear", {7'b0, dma_rx_o}, 8'h00);

        // R10 set wins and re-arm cancel
        ev_rx_done = 1; tick(); ev_rx_done = 0;
        rd(2'd1, d);
        bus_addr = 2'd2; bus_rd = 1'b1; ev_rx_done = 1;
        tick(); bus_rd = 1'b0; ev_rx_done = 0;
        chk("R10 set wins", {7'b0, dma_rx_o}, 8'h01);
        rd(2'd2, d); chk("R10 arm cancelled", {7'b0, dma_rx_o}, 8'h01);
        rd(2'd1, d); rd(2'd2, d);
        chk("R10 later clear", {7'b0, dma_rx_o}, 8'h00);

        // R6 mode fault
        wr(2'd1, 8'h08); wr(2'd0, 8'h03);
        ev_ss_fault = 1; tick(); ev_ss_fault = 0;
        chk("R6 eng off", {7'b0, eng_enable_o}, 8'h00);
        rd(2'd0, d); chk("R6 en cleared", d, 8'h02);
        rd(2'd1, d); chk("R6 flag set", d, 8'h28);
        rd(2'd2, d);
        wr(2'd1, 8'h00); wr(2'd0, 8'h03);
        ev_ss_fault = 1; tick(); ev_ss_fault = 0;
        chk("R6 no fault enable", {7'b0, eng_enable_o}, 8'h01);
        rd(2'd1, d); chk("R6 no flag", d, 8'h00);

        // R3 disable keeps state
        wr(2'd1, 8'h0F); wr(2'd0, 8'h0D);
        ev_rx_done = 1; ev_rx_ovf = 1; tick(); ev_rx_done = 0; ev_rx_ovf = 0;
        wr(2'd0, 8'h0C);
        rd(2'd0, d); chk("R3 ctrl kept", d, 8'h0C);
        chk("R3 irq kept", {7'b0, irq_o}, 8'h01);
        wr(2'd0, 8'h00);
        chk("R3 ovf irq kept", {7'b0, irq_o}, 8'h01);
        rd(2'd1, d); chk("R3 flags kept", d, 8'hCF);
        rd(2'd2, d);
        rd(2'd1, d); chk("R4 both cleared", d, 8'h0F);

        // R7 break protects
        ev_rx_done = 1; ev_tx_free = 1; tick(); ev_rx_done = 0; ev_tx_free = 0;
        brk_i = 1; brk_clr_en = 0;
        rd(2'd1, d); chk("R7 status in break", d, 8'h9F);
        rd(2'd2, d); wr(2'd2, 8'h11);
        rd(2'd1, d); chk("R7 flags held", d, 8'h9F);
        brk_i = 0;
        rd(2'd2, d); chk("R7 no arm in break", {7'b0, dma_rx_o}, 8'h01);

        // R9 arm before break, clear after
        rd(2'd1, d);
        brk_i = 1;
        rd(2'd2, d); chk("R9 held in break", {7'b0, dma_rx_o}, 8'h01);
        brk_i = 0;
        rd(2'd2, d); chk("R9 cleared after", {7'b0, dma_rx_o}, 8'h00);

        // R8 break with clear enabled
        ev_rx_done = 1; tick(); ev_rx_done = 0;
        brk_i = 1; brk_clr_en = 1;
        rd(2'd1, d); rd(2'd2, d);
        chk("R8 rx cleared", {7'b0, dma_rx_o}, 8'h00);
        wr(2'd2, 8'h00);
        brk_i = 0; brk_clr_en = 0;
        tick();
        rd(2'd1, d); chk("R8 stays cleared", d, 8'h0F);

        // R11 stop and abort
        wr(2'd0, 8'h01);
        stop_i = 1; #1;
        chk("R11 stop freezes", {7'b0, eng_enable_o}, 8'h00);
        rd(2'd0, d); chk("R11 regs kept", d, 8'h01);
        stop_i = 0; #1;
        chk("R11 resume", {7'b0, eng_enable_o}, 8'h01);
        stop_i = 1; rst_n = 0; tick();
        chk("R11 abort", {7'b0, xfer_abort_o}, 8'h01);
        rst_n = 1; stop_i = 0; tick();
        chk("R11 abort ends", {7'b0, xfer_abort_o}, 8'h00);
        rd(2'd0, d); chk("R1 ctrl after reset", d, 8'h00);
        rd(2'd1, d); chk("R1 status after reset", d, 8'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule